// File: doc/BRIEF.md
# Channel Circuit Destination Arbiter

This block lets a set of sending channel endpoints share a smaller set of receiving endpoints so that the words of one message never mix with the words of another. Each sender keeps a destination register, loaded by a set-destination command. Each sender pushes words into the block over a valid/ready stream. Every word carries a flag bit that separates control tokens from data words. The first word that reaches a free destination claims that destination for its sender. From then on the destination accepts words only from that sender, until the sender's close token has passed. Other senders aimed at the same destination are held back. They see no error, only back-pressure.

Each sender feeds a shallow holding buffer, so it can deposit a few words before it stalls. Each destination is a valid/ready output stream that carries the same flag and data fields. The output carries no sender tag. When several senders reach a free destination in the same cycle, a round-robin pointer kept for that destination picks which one goes first. A circuit has no timeout and stays open until its close token is delivered.

Back-pressure rules:
- A sender word is taken on a cycle where `src_valid` and `src_ready` are both high.
- `src_ready` falls only when that sender's buffer is full.
- A destination word moves on a cycle where `dst_valid` and `dst_ready` are both high.
- While `dst_ready` is low, the offered word and `dst_valid` hold steady.

Top module: `ccda_arbiter`

## Requirements
- R1: During and just after reset, every `dst_valid` is low, every `src_ready` is high, no destination is claimed, every destination register holds 0 and every round-robin pointer holds 0.
- R2: `src_ready[i]` is low exactly when sender i holds DEPTH words (default 2). A word is taken when `src_valid[i]` and `src_ready[i]` are both high.
- R3: A `cfg_we[i]` pulse loads `cfg_dest[i]` into sender i's destination register. Words accepted in later cycles are routed to that destination, and each word keeps the destination it was accepted with.
- R4: A word is offered on a free destination only in the cycle after its acceptance at the earliest. A word offered to a free destination claims that destination for its sender, unless the word is a close token that transfers in that same cycle.
- R5: While a destination is claimed, only the owner's words appear on it, in the order the owner pushed them. Other senders' words for that destination wait in their buffers.
- R6: The close token is a word with the flag bit at 1 and data equal to CLOSE_CODE (default 1). Data words have the flag at 0. The close token is delivered as the last word of the circuit, and its transfer frees the destination for the next cycle.
- R7: Among senders whose head words target a free destination, the first one found by scanning from that destination's pointer upward, wrapping around, wins. On a claim the pointer moves to the winner plus one.
- R8: While `dst_valid` is high and `dst_ready` is low, the next cycle shows the same word with `dst_valid` still high.
- R9: Different destinations arbitrate and transfer on their own, in the same cycle when their senders differ.
- R10: A claimed destination stays claimed through any number of idle cycles. It is never released without a close token.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | N_SRC | Per-sender set-destination strobe |
| cfg_dest | input | N_SRC x DST_W | New destination ID per sender |
| src_valid | input | N_SRC | Sender word valid |
| src_ready | output | N_SRC | Sender buffer can take a word |
| src_ctrl | input | N_SRC | Sender word flag: 1 control token, 0 data |
| src_data | input | N_SRC x DATA_W | Sender word payload |
| dst_valid | output | N_DST | Destination word valid |
| dst_ready | input | N_DST | Receiver takes the word |
| dst_ctrl | output | N_DST | Destination word flag |
| dst_data | output | N_DST x DATA_W | Destination word payload |

## Verification
A corrupted claim or owner register shows at a destination port in the very next cycle. The symptom is either a word from a second sender inside an open message, or a held sender that never gets through. A wrong round-robin pointer only shows at the next contention on that destination, as a change in the order of the winners. A wrong buffer count shows at once on `src_ready`, or a few cycles later as lost or repeated words at the output. The bench runs a behavioural model of queues and ownership next to the design and compares all outputs every cycle. It also checks the sender field of each data word, so interleaving is reported on the cycle it occurs.

// File: rtl/ccda_pkg.sv
package ccda_pkg;
  localparam int unsigned DEF_SRC    = 4;
  localparam int unsigned DEF_DST    = 4;
  localparam int unsigned DEF_DATA_W = 8;
  localparam int unsigned DEF_DEPTH  = 2;
  localparam int unsigned DEF_CLOSE  = 1;

  typedef enum logic {PORT_FREE = 1'b0, PORT_HELD = 1'b1} port_state_e;
endpackage

// File: rtl/ccda_rr_pick.sv
module ccda_rr_pick #(
  parameter int unsigned N = 4,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] ptr,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    idx = '0;
    any = 1'b0;
    for (int unsigned k = 0; k < N; k++) begin
      int unsigned c;
      c = (int'(ptr) + k) % N;
      if (!any && req[c]) begin
        any = 1'b1;
        idx = IW'(c);
      end
    end
  end
endmodule

// File: rtl/ccda_sender_buf.sv
module ccda_sender_buf #(
  parameter int unsigned W     = 11,
  parameter int unsigned DEPTH = 2,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         not_empty,
  output logic         full
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;

  assign not_empty = (cnt_q != '0);
  assign full      = (cnt_q == CW'(DEPTH));
  assign dout      = mem[rd_q];

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wr_q <= (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (pop)  rd_q <= (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);
  assert_no_underflow_R2: assert property (@(posedge clk) disable iff (rst)
    pop |-> not_empty);
  assert_count_bound_R2: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(DEPTH));
endmodule

// File: rtl/ccda_dest_port.sv
module ccda_dest_port #(
  parameter int unsigned N_SRC      = 4,
  parameter int unsigned DST_W      = 2,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned MY_ID      = 0,
  parameter int unsigned CLOSE_CODE = 1,
  localparam int unsigned SRC_W     = (N_SRC > 1) ? $clog2(N_SRC) : 1,
  localparam int unsigned WW        = DATA_W + 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [N_SRC-1:0]            head_valid,
  input  logic [N_SRC-1:0][DST_W-1:0] head_dest,
  input  logic [N_SRC-1:0][WW-1:0]    head_word,
  output logic [N_SRC-1:0]            pop,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [WW-1:0]               out_word
);
  import ccda_pkg::*;

  port_state_e       state_q;
  logic [SRC_W-1:0]  owner_q, ptr_q, rr_idx, gnt;
  logic [N_SRC-1:0]  req;
  logic              rr_any, fire, closing;

  always_comb begin
    for (int unsigned i = 0; i < N_SRC; i++)
      req[i] = head_valid[i] && (head_dest[i] == DST_W'(MY_ID));
  end

  ccda_rr_pick #(.N(N_SRC)) u_pick (
    .req (req),
    .ptr (ptr_q),
    .idx (rr_idx),
    .any (rr_any)
  );

  always_comb begin
    if (state_q == PORT_HELD) begin
      gnt       = owner_q;
      out_valid = req[owner_q];
    end else begin
      gnt       = rr_idx;
      out_valid = rr_any;
    end
    out_word = head_word[gnt];
    fire     = out_valid && out_ready;
    closing  = out_word[DATA_W] && (out_word[DATA_W-1:0] == DATA_W'(CLOSE_CODE));
    pop      = '0;
    if (fire) pop[gnt] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= PORT_FREE;
      owner_q <= '0;
      ptr_q   <= '0;
    end else begin
      if (out_valid && state_q == PORT_FREE) begin
        state_q <= PORT_HELD;
        owner_q <= gnt;
        ptr_q   <= (gnt == SRC_W'(N_SRC - 1)) ? '0 : gnt + 1'b1;
      end
      if (fire && closing) state_q <= PORT_FREE;
    end
  end

  assert_stall_stable_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word)));
  assert_claim_R4: assert property (@(posedge clk) disable iff (rst)
    (state_q == PORT_FREE && out_valid && !(fire && closing))
      |=> (state_q == PORT_HELD && owner_q == $past(gnt)));
  assert_owner_kept_R5: assert property (@(posedge clk) disable iff (rst)
    (state_q == PORT_HELD && !(fire && closing))
      |=> (state_q == PORT_HELD && $stable(owner_q)));
  assert_close_frees_R6: assert property (@(posedge clk) disable iff (rst)
    (fire && closing) |=> (state_q == PORT_FREE));
  assert_single_pop_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pop));
endmodule

// File: rtl/ccda_arbiter.sv
module ccda_arbiter #(
  parameter int unsigned N_SRC      = ccda_pkg::DEF_SRC,
  parameter int unsigned N_DST      = ccda_pkg::DEF_DST,
  parameter int unsigned DATA_W     = ccda_pkg::DEF_DATA_W,
  parameter int unsigned DEPTH      = ccda_pkg::DEF_DEPTH,
  parameter int unsigned CLOSE_CODE = ccda_pkg::DEF_CLOSE,
  localparam int unsigned DST_W     = (N_DST > 1) ? $clog2(N_DST) : 1,
  localparam int unsigned WW        = DATA_W + 1,
  localparam int unsigned BW        = DST_W + WW
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [N_SRC-1:0]             cfg_we,
  input  logic [N_SRC-1:0][DST_W-1:0]  cfg_dest,
  input  logic [N_SRC-1:0]             src_valid,
  output logic [N_SRC-1:0]             src_ready,
  input  logic [N_SRC-1:0]             src_ctrl,
  input  logic [N_SRC-1:0][DATA_W-1:0] src_data,
  output logic [N_DST-1:0]             dst_valid,
  input  logic [N_DST-1:0]             dst_ready,
  output logic [N_DST-1:0]             dst_ctrl,
  output logic [N_DST-1:0][DATA_W-1:0] dst_data
);
  logic [N_SRC-1:0][DST_W-1:0] dreg_q;
  logic [N_SRC-1:0]            head_valid, full, push, pop_s;
  logic [N_SRC-1:0][DST_W-1:0] head_dest;
  logic [N_SRC-1:0][WW-1:0]    head_word;
  logic [N_DST-1:0][N_SRC-1:0] pop_m;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    logic [BW-1:0] bout;

    always_ff @(posedge clk) begin
      if (rst)            dreg_q[i] <= '0;
      else if (cfg_we[i]) dreg_q[i] <= cfg_dest[i];
    end

    assign push[i]      = src_valid[i] && !full[i];
    assign src_ready[i] = !full[i];

    ccda_sender_buf #(.W(BW), .DEPTH(DEPTH)) u_buf (
      .clk       (clk),
      .rst       (rst),
      .push      (push[i]),
      .din       ({dreg_q[i], src_ctrl[i], src_data[i]}),
      .pop       (pop_s[i]),
      .dout      (bout),
      .not_empty (head_valid[i]),
      .full      (full[i])
    );

    assign head_dest[i] = bout[BW-1 -: DST_W];
    assign head_word[i] = bout[WW-1:0];
  end

  for (genvar d = 0; d < N_DST; d++) begin : g_dst
    logic [WW-1:0] word;

    ccda_dest_port #(
      .N_SRC(N_SRC), .DST_W(DST_W), .DATA_W(DATA_W),
      .MY_ID(d), .CLOSE_CODE(CLOSE_CODE)
    ) u_port (
      .clk        (clk),
      .rst        (rst),
      .head_valid (head_valid),
      .head_dest  (head_dest),
      .head_word  (head_word),
      .pop        (pop_m[d]),
      .out_valid  (dst_valid[d]),
      .out_ready  (dst_ready[d]),
      .out_word   (word)
    );

    assign dst_ctrl[d] = word[DATA_W];
    assign dst_data[d] = word[DATA_W-1:0];
  end

  always_comb begin
    pop_s = '0;
    for (int unsigned d = 0; d < N_DST; d++) pop_s = pop_s | pop_m[d];
  end

  assert_pop_has_word_R9: assert property (@(posedge clk) disable iff (rst)
    (pop_s & ~head_valid) == '0);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (dst_valid == '0 && src_ready == '1));
endmodule

// File: tb/ccda_arbiter_tb.sv
module ccda_arbiter_tb_top;
  localparam int N = 4, M = 4, DW = 8, DEPTH = 2, DSTW = 2, CLOSE = 1;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst;
  logic [N-1:0]           cfg_we, src_valid, src_ready, src_ctrl;
  logic [N-1:0][DSTW-1:0] cfg_dest;
  logic [N-1:0][DW-1:0]   src_data;
  logic [M-1:0]           dst_valid, dst_ready, dst_ctrl;
  logic [M-1:0][DW-1:0]   dst_data;

  ccda_arbiter dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_dest(cfg_dest),
    .src_valid(src_valid), .src_ready(src_ready), .src_ctrl(src_ctrl),
    .src_data(src_data), .dst_valid(dst_valid), .dst_ready(dst_ready),
    .dst_ctrl(dst_ctrl), .dst_data(dst_data)
  );

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural reference
  int qd[N][$];
  int qw[N][$];
  bit lk[M];
  int own[M], rr[M], dreg[N];
  bit mv[M];
  int mg[M];
  bit mrdy[N];
  int gw[M][$];
  int cur[M];

  always begin
    @(negedge clk);
    #8;
    if (!rst) begin
      for (int d = 0; d < M; d++) begin
        mv[d] = 0; mg[d] = 0;
        if (lk[d]) begin
          if (qd[own[d]].size() > 0 && qd[own[d]][0] == d) begin
            mv[d] = 1; mg[d] = own[d];
          end
        end else begin
          for (int k = 0; k < N; k++) begin
            int c;
            c = (rr[d] + k) % N;
            if (!mv[d] && qd[c].size() > 0 && qd[c][0] == d) begin
              mv[d] = 1; mg[d] = c;
            end
          end
        end
        chk(dst_valid[d] == mv[d], "R4", "dst_valid vs model", dst_valid[d], mv[d]);
        if (mv[d])
          chk({dst_ctrl[d], dst_data[d]} == qw[mg[d]][0], "R5", "dst word vs model",
              {dst_ctrl[d], dst_data[d]}, qw[mg[d]][0]);
        if (dst_valid[d] && dst_ready[d]) begin
          gw[d].push_back({dst_ctrl[d], dst_data[d]});
          if (dst_ctrl[d]) begin
            if (dst_data[d] == CLOSE) cur[d] = -1;
          end else begin
            int sid;
            sid = dst_data[d][7:6];
            if (cur[d] != -1 && cur[d] != sid)
              chk(0, "R5", "interleaved sender at destination", sid, cur[d]);
            cur[d] = sid;
          end
        end
      end
      for (int i = 0; i < N; i++) begin
        mrdy[i] = qd[i].size() < DEPTH;
        chk(src_ready[i] == mrdy[i], "R2", "src_ready vs model", src_ready[i], mrdy[i]);
      end
    end
  end

  always @(posedge clk) begin
    if (rst) begin
      for (int d = 0; d < M; d++) begin lk[d] = 0; own[d] = 0; rr[d] = 0; cur[d] = -1; end
      for (int i = 0; i < N; i++) begin qd[i].delete(); qw[i].delete(); dreg[i] = 0; end
    end else begin
      for (int d = 0; d < M; d++) begin
        if (mv[d]) begin
          int g;
          g = mg[d];
          if (!lk[d]) begin rr[d] = (g + 1) % N; lk[d] = 1; own[d] = g; end
          if (dst_ready[d]) begin
            int w;
            w = qw[g].pop_front();
            void'(qd[g].pop_front());
            if (w == ((1 << DW) | CLOSE)) lk[d] = 0;
          end
        end
      end
      for (int i = 0; i < N; i++) begin
        if (src_valid[i] && mrdy[i]) begin
          qd[i].push_back(dreg[i]);
          qw[i].push_back({src_ctrl[i], src_data[i]});
        end
        if (cfg_we[i]) dreg[i] = cfg_dest[i];
      end
    end
  end

  task automatic step(); @(negedge clk); endtask

  task automatic idle(input int n);
    repeat (n) step();
  endtask

  task automatic send(input int i, input bit c, input int d);
    step();
    src_valid[i] = 1; src_ctrl[i] = c; src_data[i] = d[DW-1:0];
    #8;
    while (!src_ready[i]) begin step(); #8; end
    step();
    src_valid[i] = 0;
  endtask

  initial begin
    #(20 * 150000);
    chk(0, "R1", "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int left[N];
    bit acc[N];
    rst = 1; cfg_we = '0; cfg_dest = '0; src_valid = '0; src_ctrl = '0;
    src_data = '0; dst_ready = '1;
    idle(3); #8;
    chk(dst_valid == '0, "R1", "dst_valid in reset", dst_valid, 0);
    chk(src_ready == '1, "R1", "src_ready in reset", src_ready, 'hF);
    step(); rst = 0;
    #8;
    chk(dst_valid == '0 && src_ready == '1, "R1", "idle after reset", dst_valid, 0);

    // R3: reroute sender 2 to destination 3
    step(); cfg_we[2] = 1; cfg_dest[2] = 3;
    step(); cfg_we[2] = 0; src_valid[2] = 1; src_ctrl[2] = 0; src_data[2] = 8'h85;
    #8;
    chk(src_ready[2], "R2", "empty sender ready", src_ready[2], 1);
    chk(dst_valid[3] == 0, "R4", "no offer in accept cycle", dst_valid[3], 0);
    step(); src_valid[2] = 0;
    #8;
    chk(dst_valid[3] && dst_data[3] == 8'h85, "R3", "word on new destination", dst_data[3], 'h85);

    // R10: destination 3 held by sender 2, sender 0 waits
    step(); cfg_we[0] = 1; cfg_dest[0] = 3;
    step(); cfg_we[0] = 0;
    send(0, 0, 8'h07);
    for (int k = 0; k < 40; k++) begin
      step(); #8;
      chk(dst_valid[3] == 0, "R10", "held circuit blocks other sender", dst_valid[3], 0);
    end

    // R6: close frees destination
    src_valid[2] = 1; src_ctrl[2] = 1; src_data[2] = CLOSE;
    step(); src_valid[2] = 0;
    #8;
    chk(dst_valid[3] && dst_ctrl[3] && dst_data[3] == CLOSE, "R6", "close delivered",
        {dst_ctrl[3], dst_data[3]}, 'h101);
    step(); #8;
    chk(dst_valid[3] && !dst_ctrl[3] && dst_data[3] == 8'h07, "R6", "waiter after close",
        dst_data[3], 'h07);
    send(0, 1, CLOSE);
    idle(4);

    // R2/R8: back-pressure on destination 0 from sender 1
    for (int d = 0; d < M; d++) gw[d].delete();
    dst_ready[0] = 0;
    send(1, 0, 8'h41);
    send(1, 0, 8'h42);
    src_valid[1] = 1; src_ctrl[1] = 0; src_data[1] = 8'h43;
    #8;
    chk(src_ready[1] == 0, "R2", "full sender not ready", src_ready[1], 0);
    chk(dst_valid[0] && dst_data[0] == 8'h41, "R8", "stalled offer", dst_data[0], 'h41);
    step(); #8;
    chk(dst_valid[0] && dst_data[0] == 8'h41, "R8", "stalled offer stable", dst_data[0], 'h41);
    dst_ready[0] = 1;
    while (!src_ready[1]) begin step(); #8; end
    step(); src_valid[1] = 0;
    send(1, 1, CLOSE);
    idle(5);
    chk(gw[0].size() == 4, "R5", "dest0 word count", gw[0].size(), 4);
    if (gw[0].size() == 4) begin
      chk(gw[0][0] == 'h41 && gw[0][1] == 'h42 && gw[0][2] == 'h43 && gw[0][3] == 'h101,
          "R5", "dest0 order", gw[0][2], 'h43);
    end

    // R7: round robin on destination 1
    cfg_we = 4'b0011; cfg_dest[0] = 1; cfg_dest[1] = 1;
    step(); cfg_we = '0;
    src_valid[0] = 1; src_ctrl[0] = 0; src_data[0] = 8'h10;
    src_valid[1] = 1; src_ctrl[1] = 0; src_data[1] = 8'h50;
    step();
    src_ctrl[0] = 1; src_data[0] = CLOSE; src_ctrl[1] = 1; src_data[1] = CLOSE;
    step(); src_valid = '0;
    idle(8);
    chk(gw[1].size() == 4, "R7", "dest1 word count", gw[1].size(), 4);
    if (gw[1].size() == 4)
      chk(gw[1][0] == 'h10 && gw[1][1] == 'h101 && gw[1][2] == 'h50 && gw[1][3] == 'h101,
          "R7", "first contention order", gw[1][2], 'h50);
    cfg_we[3] = 1; cfg_dest[3] = 1;
    step(); cfg_we = '0;
    src_valid[1] = 1; src_ctrl[1] = 0; src_data[1] = 8'h51;
    src_valid[3] = 1; src_ctrl[3] = 0; src_data[3] = 8'hD3;
    step();
    src_ctrl[1] = 1; src_data[1] = CLOSE; src_ctrl[3] = 1; src_data[3] = CLOSE;
    step(); src_valid = '0;
    idle(8);
    chk(gw[1].size() == 8 && gw[1][4] == 'hD3, "R7", "pointer rotated past sender 1",
        gw[1].size() > 4 ? gw[1][4] : 0, 'hD3);

    // R9: two destinations in the same cycle
    cfg_we = 4'b0011; cfg_dest[0] = 0; cfg_dest[1] = 2;
    step(); cfg_we = '0;
    src_valid[0] = 1; src_ctrl[0] = 0; src_data[0] = 8'h05;
    src_valid[1] = 1; src_ctrl[1] = 0; src_data[1] = 8'h4A;
    step(); src_valid = '0;
    #8;
    chk(dst_valid[0] && dst_valid[2], "R9", "parallel destinations", {dst_valid[2], dst_valid[0]}, 3);
    send(0, 1, CLOSE);
    send(1, 1, CLOSE);
    idle(4);

    // random traffic against the model
    for (int i = 0; i < N; i++) begin left[i] = 0; acc[i] = 0; end
    for (int cyc = 0; cyc < 5000; cyc++) begin
      step();
      cfg_we = '0;
      for (int i = 0; i < N; i++) begin
        if (!src_valid[i] || acc[i]) begin
          if (src_valid[i]) left[i]--;
          src_valid[i] = 0;
          if (left[i] == 0) begin
            if ($urandom % 4 == 0) begin cfg_we[i] = 1; cfg_dest[i] = DSTW'($urandom % M); end
            left[i] = 2 + $urandom % 4;
          end else if ($urandom % 3 != 0) begin
            src_valid[i] = 1;
            if (left[i] == 1) begin src_ctrl[i] = 1; src_data[i] = CLOSE; end
            else begin src_ctrl[i] = 0; src_data[i] = {i[1:0], 6'($urandom)}; end
          end
        end
      end
      for (int d = 0; d < M; d++) dst_ready[d] = ($urandom % 4) != 0;
      #8;
      for (int i = 0; i < N; i++) acc[i] = src_valid[i] && src_ready[i];
    end
    step(); src_valid = '0; dst_ready = '1;
    idle(5);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule